// File: doc/BRIEF.md
# Shared LCD-Segment / GPIO Pin Controller

This block owns a bank of multiplexed pins. Each pin in the segment group either drives an LCD segment or works as a general-purpose digital I/O, as set by a per-pin function bit. A small group of dedicated pins has no LCD function and is always digital I/O. Software reaches every setting through a byte-wide register port. The control byte of a segment pin carries both segment data and that pin's I/O direction and data. Software therefore updates it by reading the byte, masking the bits it wants to change and writing the byte back.

Each pin also has a 3-bit resource selector. The selector can pass the pin's synchronised input to one of two counter clock lines, or to one of two interrupt lines as a one-clock pulse on a rising or a falling edge. The block has no state machine. It holds register storage and a two-stage input synchroniser, and the rest is combinational muxing and edge qualification. The waveforms, pad electronics, counters and interrupt controller are outside this block.

Top module: `lcdio_pinmux`

## Requirements
- R1: While reset is asserted and on the first cycle after it, every pad output enable is 0 and every LCD enable is 0. All stored registers read back as 0.
- R2: Function byte k at address 0x00+k, bit j, selects pin 8k+j. When the bit is 1, the pin's LCD enable is 1, its output enable is 0 and its pad output is 0, whatever its direction bit says.
- R3: In digital I/O mode, a pin's output enable equals its direction bit (1 = output) and its pad output equals its data bit.
- R4: Segment pin i has a control byte at address 0x10+i. Bit 3 of that byte is the pin's direction and bit 0 is its data.
- R5: A read of any function or control byte returns the full 8 bits last written. A read of a selector byte returns its 3 stored bits, with the upper bits 0. An unmapped address reads 0.
- R6: The data bit of a digital I/O pin whose direction is input reads back as the pad level delayed through two flops. For an output pin, or for a pin in LCD mode, it reads back the stored bit.
- R7: Dedicated pin d has a direction byte at 0x80+d that uses bit 7 and a data byte at 0x90+d that uses bit 4. It never has an LCD enable.
- R8: The selector for pin p is at 0x40+p, bits 2:0. Code 2 routes the synchronised level to the counter-0 clock and code 3 routes it to the counter-1 clock. Codes 0 and 1 route nothing.
- R9: Codes 4 and 5 give a one-clock pulse on the high-priority and low-priority interrupt line, respectively, when the synchronised level rises. Codes 6 and 7 do the same on a falling edge. A pad change lands on the interrupt line on the second clock edge and is gone after the third.
- R10: A pin in LCD mode adds nothing to any routed line.
- R11: When several pins select the same resource, the routed line is the OR of their qualified contributions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register address (write and read) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Combinational read data for `addr` |
| pad_in | input | NSEG+NDED | Pad input levels |
| pad_oe | output | NSEG+NDED | Pad output enables |
| pad_out | output | NSEG+NDED | Pad output values |
| lcd_en | output | NSEG | Segment pin is in LCD mode |
| t0_clk | output | 1 | Counter-0 clock input |
| t1_clk | output | 1 | Counter-1 clock input |
| int0 | output | 1 | High-priority interrupt pulse |
| int1 | output | 1 | Low-priority interrupt pulse |

## Verification
The bench switches an output pin into LCD mode and checks that its driver turns off. A design that gave the direction bit priority would keep driving a pin that the LCD also drives. It reads control bytes of input pins with other bits set, to catch a read-back that drops the segment bits or returns the stored data bit instead of the pad. It samples each interrupt line on the exact cycle of the expected pulse and on the cycle after. This catches a wrong edge polarity, swapped priority lines, a pulse that lasts two cycles, and a reserved code that wrongly routes the pin. Further cases check that LCD-mode pins are excluded from routing and that shared resources combine by OR.

// File: rtl/lcdio_pkg.sv
package lcdio_pkg;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 8;
    localparam int SEL_W  = 3;

    localparam logic [ADDR_W-1:0] FSEL_BASE = 8'h00;
    localparam logic [ADDR_W-1:0] SEG_BASE  = 8'h10;
    localparam logic [ADDR_W-1:0] SEL_BASE  = 8'h40;
    localparam logic [ADDR_W-1:0] DDIR_BASE = 8'h80;
    localparam logic [ADDR_W-1:0] DDAT_BASE = 8'h90;

    localparam int SEG_DIR_BIT = 3;
    localparam int SEG_DAT_BIT = 0;
    localparam int DED_DIR_BIT = 7;
    localparam int DED_DAT_BIT = 4;

    typedef enum logic [SEL_W-1:0] {
        RS_NONE    = 3'd0,
        RS_RSVD    = 3'd1,
        RS_CLK0    = 3'd2,
        RS_CLK1    = 3'd3,
        RS_HI_RISE = 3'd4,
        RS_LO_RISE = 3'd5,
        RS_HI_FALL = 3'd6,
        RS_LO_FALL = 3'd7
    } rsel_e;
endpackage

// File: rtl/lcdio_sync.sv
module lcdio_sync #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= d_i;
            stage2_q <= stage1_q;
        end
    end

    assign q_o = stage2_q;

    // R6: second stage follows first stage one cycle later
    assert_sync_chain_R6: assert property (@(posedge clk) disable iff (!rst_n)
        stage2_q == $past(stage1_q));
endmodule

// File: rtl/lcdio_regs.sv
module lcdio_regs
    import lcdio_pkg::*;
#(
    parameter int NSEG = 8,
    parameter int NDED = 2,
    localparam int NP  = NSEG + NDED,
    localparam int NFB = (NSEG + 7) / 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [DATA_W-1:0]          wdata,
    input  logic [NP-1:0]              sync_i,
    output logic [DATA_W-1:0]          rdata,
    output logic [NSEG-1:0]            fsel_o,
    output logic [NP-1:0]              dir_o,
    output logic [NP-1:0]              dat_o,
    output logic [NP-1:0][SEL_W-1:0]   sel_o
);
    logic [NFB*8-1:0]          fsel_q;
    logic [DATA_W-1:0]         seg_q  [NSEG];
    logic [NP-1:0][SEL_W-1:0]  sel_q;
    logic [DATA_W-1:0]         ddir_q [NDED];
    logic [DATA_W-1:0]         ddat_q [NDED];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsel_q <= '0;
            sel_q  <= '0;
            for (int i = 0; i < NSEG; i++) seg_q[i] <= '0;
            for (int d = 0; d < NDED; d++) begin
                ddir_q[d] <= '0;
                ddat_q[d] <= '0;
            end
        end else if (wr_en) begin
            for (int k = 0; k < NFB; k++)
                if (addr == FSEL_BASE + 8'(k)) fsel_q[k*8 +: 8] <= wdata;
            for (int i = 0; i < NSEG; i++)
                if (addr == SEG_BASE + 8'(i)) seg_q[i] <= wdata;
            for (int p = 0; p < NP; p++)
                if (addr == SEL_BASE + 8'(p)) sel_q[p] <= wdata[SEL_W-1:0];
            for (int d = 0; d < NDED; d++) begin
                if (addr == DDIR_BASE + 8'(d)) ddir_q[d] <= wdata;
                if (addr == DDAT_BASE + 8'(d)) ddat_q[d] <= wdata;
            end
        end
    end

    // Read-back: full stored bytes, data bit of input pins replaced by pad level
    always_comb begin
        rdata = '0;
        for (int k = 0; k < NFB; k++)
            if (addr == FSEL_BASE + 8'(k)) rdata = fsel_q[k*8 +: 8];
        for (int i = 0; i < NSEG; i++) begin
            if (addr == SEG_BASE + 8'(i)) begin
                rdata = seg_q[i];
                if (!fsel_q[i] && !seg_q[i][SEG_DIR_BIT])
                    rdata[SEG_DAT_BIT] = sync_i[i];
            end
        end
        for (int p = 0; p < NP; p++)
            if (addr == SEL_BASE + 8'(p)) rdata = {{(DATA_W-SEL_W){1'b0}}, sel_q[p]};
        for (int d = 0; d < NDED; d++) begin
            if (addr == DDIR_BASE + 8'(d)) rdata = ddir_q[d];
            if (addr == DDAT_BASE + 8'(d)) begin
                rdata = ddat_q[d];
                if (!ddir_q[d][DED_DIR_BIT])
                    rdata[DED_DAT_BIT] = sync_i[NSEG+d];
            end
        end
    end

    assign fsel_o = fsel_q[NSEG-1:0];
    assign sel_o  = sel_q;

    for (genvar i = 0; i < NSEG; i++) begin : g_seg
        assign dir_o[i] = seg_q[i][SEG_DIR_BIT];
        assign dat_o[i] = seg_q[i][SEG_DAT_BIT];

        // R5: a written control byte is held intact for read-modify-write
        assert_seg_store_R5: assert property (@(posedge clk) disable iff (!rst_n)
            $past(wr_en && addr == SEG_BASE + 8'(i)) |-> seg_q[i] == $past(wdata));
    end

    for (genvar d = 0; d < NDED; d++) begin : g_ded
        assign dir_o[NSEG+d] = ddir_q[d][DED_DIR_BIT];
        assign dat_o[NSEG+d] = ddat_q[d][DED_DAT_BIT];
    end
endmodule

// File: rtl/lcdio_route.sv
module lcdio_route
    import lcdio_pkg::*;
#(
    parameter int NP = 10
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NP-1:0]             sync_i,
    input  logic [NP-1:0]             en_i,
    input  logic [NP-1:0][SEL_W-1:0]  sel_i,
    output logic                      t0_o,
    output logic                      t1_o,
    output logic                      int0_o,
    output logic                      int1_o
);
    logic [NP-1:0] prev_q;
    logic [NP-1:0] rise_w;
    logic [NP-1:0] fall_w;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= sync_i;
    end

    assign rise_w = sync_i & ~prev_q;
    assign fall_w = ~sync_i & prev_q;

    always_comb begin
        t0_o   = 1'b0;
        t1_o   = 1'b0;
        int0_o = 1'b0;
        int1_o = 1'b0;
        for (int k = 0; k < NP; k++) begin
            if (en_i[k]) begin
                case (rsel_e'(sel_i[k]))
                    RS_CLK0:    t0_o   = t0_o   | sync_i[k];
                    RS_CLK1:    t1_o   = t1_o   | sync_i[k];
                    RS_HI_RISE: int0_o = int0_o | rise_w[k];
                    RS_LO_RISE: int1_o = int1_o | rise_w[k];
                    RS_HI_FALL: int0_o = int0_o | fall_w[k];
                    RS_LO_FALL: int1_o = int1_o | fall_w[k];
                    default:    ;
                endcase
            end
        end
    end

    for (genvar k = 0; k < NP; k++) begin : g_chk
        // R9: a qualified rising edge on a high-priority pin raises int0
        assert_int0_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (en_i[k] && sel_i[k] == RS_HI_RISE && $rose(sync_i[k])) |-> int0_o);
        // R9: a qualified falling edge on a low-priority pin raises int1
        assert_int1_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (en_i[k] && sel_i[k] == RS_LO_FALL && $fell(sync_i[k])) |-> int1_o);
    end
endmodule

// File: rtl/lcdio_pinmux.sv
module lcdio_pinmux
    import lcdio_pkg::*;
#(
    parameter int NSEG = 8,
    parameter int NDED = 2,
    localparam int NP  = NSEG + NDED
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [7:0]        addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    input  logic [NP-1:0]     pad_in,
    output logic [NP-1:0]     pad_oe,
    output logic [NP-1:0]     pad_out,
    output logic [NSEG-1:0]   lcd_en,
    output logic              t0_clk,
    output logic              t1_clk,
    output logic              int0,
    output logic              int1
);
    logic [NP-1:0]            sync_w;
    logic [NSEG-1:0]          fsel_w;
    logic [NP-1:0]            dir_w;
    logic [NP-1:0]            dat_w;
    logic [NP-1:0][SEL_W-1:0] sel_w;
    logic [NP-1:0]            gpio_w;

    lcdio_sync #(.W(NP)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pad_in),
        .q_o   (sync_w)
    );

    lcdio_regs #(.NSEG(NSEG), .NDED(NDED)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .addr   (addr),
        .wdata  (wdata),
        .sync_i (sync_w),
        .rdata  (rdata),
        .fsel_o (fsel_w),
        .dir_o  (dir_w),
        .dat_o  (dat_w),
        .sel_o  (sel_w)
    );

    for (genvar i = 0; i < NP; i++) begin : g_mode
        if (i < NSEG) begin : g_shared
            assign gpio_w[i] = ~fsel_w[i];
        end else begin : g_dedicated
            assign gpio_w[i] = 1'b1;
        end
    end

    assign lcd_en  = fsel_w;
    assign pad_oe  = gpio_w & dir_w;
    assign pad_out = gpio_w & dat_w;

    lcdio_route #(.NP(NP)) u_route (
        .clk    (clk),
        .rst_n  (rst_n),
        .sync_i (sync_w),
        .en_i   (gpio_w),
        .sel_i  (sel_w),
        .t0_o   (t0_clk),
        .t1_o   (t1_clk),
        .int0_o (int0),
        .int1_o (int1)
    );

    // R1: first cycle out of reset leaves every pad undriven
    assert_reset_inputs_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (pad_oe == '0 && lcd_en == '0));
    // R2: a pin handed to the LCD never has its GPIO driver on
    assert_lcd_no_drive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (lcd_en & pad_oe[NSEG-1:0]) == '0);
endmodule

// File: tb/sim_lcdio_pinmux.sv
module sim_lcdio_pinmux;
    localparam int NSEG = 8;
    localparam int NDED = 2;
    localparam int NP   = NSEG + NDED;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            wr_en = 1'b0;
    logic [7:0]      addr = '0;
    logic [7:0]      wdata = '0;
    logic [7:0]      rdata;
    logic [NP-1:0]   pads = '0;
    logic [NP-1:0]   pad_oe, pad_out;
    logic [NSEG-1:0] lcd_en;
    logic            t0_clk, t1_clk, int0, int1;

    int checks = 0;
    int errors = 0;

    logic [7:0] fsel_m;
    logic [7:0] seg_m  [NSEG];
    logic [2:0] sel_m  [NP];
    logic [7:0] ddir_m [NDED];
    logic [7:0] ddat_m [NDED];

    always #5 clk = ~clk;

    lcdio_pinmux #(.NSEG(NSEG), .NDED(NDED)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .pad_in(pads), .pad_oe(pad_oe), .pad_out(pad_out),
        .lcd_en(lcd_en), .t0_clk(t0_clk), .t1_clk(t1_clk), .int0(int0), .int1(int1)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic is_gpio(int i);
        if (i < NSEG) return ~fsel_m[i];
        return 1'b1;
    endfunction

    function automatic logic dir_of(int i);
        if (i < NSEG) return seg_m[i][3];
        return ddir_m[i-NSEG][7];
    endfunction

    function automatic logic dat_of(int i);
        if (i < NSEG) return seg_m[i][0];
        return ddat_m[i-NSEG][4];
    endfunction

    function automatic logic [NP-1:0] exp_oe();
        logic [NP-1:0] v = '0;
        for (int i = 0; i < NP; i++) v[i] = is_gpio(i) & dir_of(i);
        return v;
    endfunction

    function automatic logic [NP-1:0] exp_out();
        logic [NP-1:0] v = '0;
        for (int i = 0; i < NP; i++) v[i] = is_gpio(i) & dat_of(i);
        return v;
    endfunction

    function automatic logic exp_level(logic [2:0] code);
        logic v = 1'b0;
        for (int i = 0; i < NP; i++)
            if (is_gpio(i) && sel_m[i] == code) v = v | pads[i];
        return v;
    endfunction

    function automatic logic [7:0] exp_rd(logic [7:0] a);
        logic [7:0] v = '0;
        if (a == 8'h00) v = fsel_m;
        for (int i = 0; i < NSEG; i++)
            if (a == 8'h10 + 8'(i)) begin
                v = seg_m[i];
                if (!fsel_m[i] && !seg_m[i][3]) v[0] = pads[i];
            end
        for (int p = 0; p < NP; p++)
            if (a == 8'h40 + 8'(p)) v = {5'b0, sel_m[p]};
        for (int d = 0; d < NDED; d++) begin
            if (a == 8'h80 + 8'(d)) v = ddir_m[d];
            if (a == 8'h90 + 8'(d)) begin
                v = ddat_m[d];
                if (!ddir_m[d][7]) v[4] = pads[NSEG+d];
            end
        end
        return v;
    endfunction

    task automatic clear_model();
        fsel_m = '0;
        for (int i = 0; i < NSEG; i++) seg_m[i] = '0;
        for (int p = 0; p < NP; p++) sel_m[p] = '0;
        for (int d = 0; d < NDED; d++) begin ddir_m[d] = '0; ddat_m[d] = '0; end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        pads  = '0;
        clear_model();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (a == 8'h00) fsel_m = d;
        for (int i = 0; i < NSEG; i++) if (a == 8'h10 + 8'(i)) seg_m[i] = d;
        for (int p = 0; p < NP; p++) if (a == 8'h40 + 8'(p)) sel_m[p] = d[2:0];
        for (int q = 0; q < NDED; q++) begin
            if (a == 8'h80 + 8'(q)) ddir_m[q] = d;
            if (a == 8'h90 + 8'(q)) ddat_m[q] = d;
        end
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] a);
        @(negedge clk);
        addr = a;
        #1 chk(tag, 32'(rdata), 32'(exp_rd(a)));
    endtask

    task automatic settle_chk(input string tag);
        repeat (3) @(negedge clk);
        #1;
        chk({tag, " oe R3"}, 32'(pad_oe), 32'(exp_oe()));
        chk({tag, " out R3"}, 32'(pad_out), 32'(exp_out()));
        chk({tag, " lcd R2"}, 32'(lcd_en), 32'(fsel_m));
        chk({tag, " t0 R8"}, 32'(t0_clk), 32'(exp_level(3'd2)));
        chk({tag, " t1 R8"}, 32'(t1_clk), 32'(exp_level(3'd3)));
        chk({tag, " int0 quiet R9"}, 32'(int0), 32'd0);
        chk({tag, " int1 quiet R9"}, 32'(int1), 32'd0);
    endtask

    // Drive one pad and sample both interrupt lines in the pulse cycle and after
    task automatic edge_chk(input string tag, input int pin, input logic v,
                            input logic e0, input logic e1);
        @(negedge clk);
        pads[pin] = v;
        @(posedge clk); @(posedge clk); #1;
        chk({tag, " pulse int0"}, 32'(int0), 32'(e0));
        chk({tag, " pulse int1"}, 32'(int1), 32'(e1));
        @(posedge clk); #1;
        chk({tag, " after int0"}, 32'(int0), 32'd0);
        chk({tag, " after int1"}, 32'(int1), 32'd0);
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] a;
        void'($urandom(32'd20240611));
        clear_model();
        #1;
        chk("R1 oe in reset", 32'(pad_oe), 32'd0);
        chk("R1 lcd in reset", 32'(lcd_en), 32'd0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 oe after reset", 32'(pad_oe), 32'd0);
        chk("R1 lcd after reset", 32'(lcd_en), 32'd0);
        rd_chk("R1 seg0 reads 0", 8'h10);
        rd_chk("R1 ddir1 reads 0", 8'h81);

        // R4 / R3: pin 0 output high, then R2 LCD overrides it
        wr(8'h10, 8'h09);
        #1 chk("R4 pin0 oe", 32'(pad_oe[0]), 32'd1);
        chk("R4 pin0 out", 32'(pad_out[0]), 32'd1);
        wr(8'h00, 8'h01);
        #1 chk("R2 pin0 oe off in LCD", 32'(pad_oe[0]), 32'd0);
        chk("R2 pin0 lcd_en", 32'(lcd_en[0]), 32'd1);
        chk("R2 pin0 out low in LCD", 32'(pad_out[0]), 32'd0);
        rd_chk("R6 lcd pin reads stored", 8'h10);
        wr(8'h00, 8'h00);
        #1 chk("R3 pin0 oe restored", 32'(pad_oe[0]), 32'd1);

        // R5 / R6: input pin with segment bits set reads pad level in bit 0
        wr(8'h11, 8'hA6);
        @(negedge clk); pads[1] = 1'b1;
        repeat (3) @(negedge clk);
        rd_chk("R6 input pin1 reads pad", 8'h11);
        rd_chk("R5 output pin0 reads stored", 8'h10);
        wr(8'h00, 8'h5A);
        rd_chk("R5 function byte", 8'h00);
        wr(8'h00, 8'h00);
        wr(8'h45, 8'hFF);
        rd_chk("R5 selector upper bits zero", 8'h45);
        rd_chk("R5 unmapped reads zero", 8'h3F);
        wr(8'h45, 8'h00);

        // R7: dedicated pins
        wr(8'h80, 8'h80);
        wr(8'h90, 8'h10);
        #1 chk("R7 ded0 oe", 32'(pad_oe[NSEG]), 32'd1);
        chk("R7 ded0 out", 32'(pad_out[NSEG]), 32'd1);
        wr(8'h91, 8'hFF);
        rd_chk("R7 R6 ded1 input reads pad 0", 8'h91);
        wr(8'h81, 8'h7F);
        #1 chk("R7 ded1 bit7 clear stays input", 32'(pad_oe[NSEG+1]), 32'd0);
        settle_chk("R7 settle");

        // R9: edges on pin 4
        wr(8'h44, 8'h04);
        edge_chk("R9 code4 rise", 4, 1'b1, 1'b1, 1'b0);
        edge_chk("R9 code4 fall ignored", 4, 1'b0, 1'b0, 1'b0);
        wr(8'h44, 8'h05);
        edge_chk("R9 code5 rise", 4, 1'b1, 1'b0, 1'b1);
        wr(8'h44, 8'h06);
        edge_chk("R9 code6 fall", 4, 1'b0, 1'b1, 1'b0);
        wr(8'h44, 8'h07);
        edge_chk("R9 code7 rise ignored", 4, 1'b1, 1'b0, 1'b0);
        edge_chk("R9 code7 fall", 4, 1'b0, 1'b0, 1'b1);

        // R8: reserved code routes nothing
        wr(8'h44, 8'h01);
        edge_chk("R8 code1 rise quiet", 4, 1'b1, 1'b0, 1'b0);
        settle_chk("R8 code1 level");

        // R10: LCD pin excluded from interrupts and clocks
        wr(8'h44, 8'h04);
        wr(8'h00, 8'h10);
        edge_chk("R10 lcd pin fall", 4, 1'b0, 1'b0, 1'b0);
        edge_chk("R10 lcd pin rise", 4, 1'b1, 1'b0, 1'b0);
        wr(8'h44, 8'h02);
        settle_chk("R10 lcd pin clock");
        wr(8'h00, 8'h00);
        settle_chk("R8 pin4 clock0 high");

        // R11: two pins on counter-1 clock
        wr(8'h44, 8'h00);
        wr(8'h42, 8'h03);
        wr(8'h43, 8'h03);
        @(negedge clk); pads[2] = 1'b0; pads[3] = 1'b1;
        settle_chk("R11 one of two");
        @(negedge clk); pads[3] = 1'b0;
        settle_chk("R11 none");
        @(negedge clk); pads[2] = 1'b1;
        settle_chk("R11 other");

        // Random phase from a fresh reset
        do_reset();
        for (int n = 0; n < 300; n++) begin
            case ($urandom % 5)
                0: a = 8'h00;
                1: a = 8'h10 + 8'($urandom % NSEG);
                2: a = 8'h40 + 8'($urandom % NP);
                3: a = 8'h80 + 8'($urandom % NDED);
                default: a = 8'h90 + 8'($urandom % NDED);
            endcase
            wr(a, 8'($urandom));
            if ($urandom % 2 == 1) begin
                @(negedge clk);
                pads = NP'($urandom);
            end
            settle_chk("rand");
            rd_chk("R5 R6 rand readback", a);
            rd_chk("R5 rand other readback", 8'h10 + 8'($urandom % NSEG));
        end

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule